// File: doc/BRIEF.md
# Two-Cycle Reflected CRC Advance Unit

This unit moves a reflected 32-bit CRC state forward by 8, 16 or 32 bit times, as if that many zero bits had been shifted through the register. Software first folds its data bytes into the state with an XOR, then issues one operation to absorb them. Two generator polynomials are available: the common Ethernet/zip CRC-32 (normal form 0x04C11DB7) and the Castagnoli CRC-32C (normal form 0x1EDC6F41).

The unit does not loop over the bits. It uses Barrett reduction. In the first cycle the top bits of the state are multiplied, carry-less, by a reciprocal constant that is computed at elaboration. This gives the quotient, which is held in a register. In the second cycle the quotient is multiplied by the polynomial and the product is folded into the shifted state. A start pulse captures the operands. The result appears with a done pulse one clock later and then stays unchanged until the next start.

Top module: `crcb_unit`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` is 0 and `result_o` is 0 until the first start.
- R2: `done_o` is 1 in the cycle right after each cycle in which `start_i` is 1, and 0 in every other cycle.
- R3: With `poly_sel_i`=0, the result equals n applications of the step x = (x >> 1) ^ (x[0] ? 0xEDB88320 : 0) to the captured state.
- R4: With `poly_sel_i`=1, the result equals n applications of the step x = (x >> 1) ^ (x[0] ? 0x82F63B78 : 0) to the captured state.
- R5: `width_i` selects n: 0 gives 8, 1 gives 16, and both 2 and 3 give 32.
- R6: Changes to `state_i`, `width_i` or `poly_sel_i` in a cycle without a start have no effect. `result_o` keeps the last result until the next start.
- R7: Starts in consecutive cycles each produce their own correct result, one cycle apart.
- R8: A captured state of zero gives a result of zero, for every width and polynomial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Captures the operands and begins an operation |
| state_i | input | 32 | Reflected CRC state to advance |
| width_i | input | 2 | Advance length: 0 is 8, 1 is 16, 2 or 3 is 32 bits |
| poly_sel_i | input | 1 | 0 selects CRC-32, 1 selects CRC-32C |
| result_o | output | 32 | Advanced state, valid while done_o is 1 and held afterwards |
| done_o | output | 1 | One-cycle pulse one clock after start_i |

## Verification
A wrong quotient register or a wrong reciprocal constant changes the result in the very cycle `done_o` rises, so every comparison against the bench's bit-serial model finds it on the first affected operation. A fault in the width decode affects only the lengths that decode to a wrong n, which is why all four width codes are driven under both polynomials. A fault in the capture enable shows up as a `result_o` that changes between operations, or as a mix of two operations' operands when starts come back to back.

// File: rtl/crcb_pkg.sv
package crcb_pkg;

  localparam int unsigned CRC_W = 32;

  typedef logic [CRC_W-1:0] crc_word_t;

  // Bit-order reversal of one CRC word.
  function automatic crc_word_t rev_word(input crc_word_t v);
    crc_word_t r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  // Number of zero bits absorbed for each width code (R5).
  function automatic int unsigned adv_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return 32;
    endcase
  endfunction

  // Quotient of x^(2W) divided by {1,p}, with its leading bit removed.
  function automatic crc_word_t barrett_mu(input crc_word_t p);
    logic [2*CRC_W:0] rem;
    logic [2*CRC_W:0] gen;
    crc_word_t        quo;
    rem = '0;
    rem[2*CRC_W] = 1'b1;
    quo = '0;
    for (int i = 2*CRC_W; i >= CRC_W; i--) begin
      if (rem[i]) begin
        gen = {{CRC_W{1'b0}}, 1'b1, p} << (i - CRC_W);
        rem = rem ^ gen;
        if (i < 2*CRC_W) quo[i-CRC_W] = 1'b1;
      end
    end
    return quo;
  endfunction

endpackage

// File: rtl/crcb_clmul.sv
// Carry-less product of two W-bit operands. HIGH selects which W bits of the
// 2W-1 bit product come out: 0 gives bits W-1..0, 1 gives bits 2W-1..W.
module crcb_clmul #(
  parameter int unsigned W    = 32,
  parameter bit          HIGH = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);

  localparam int BASE = HIGH ? int'(W) : 0;

  for (genvar k = 0; k < W; k++) begin : g_bit
    always_comb begin
      logic acc;
      acc = 1'b0;
      for (int i = 0; i < int'(W); i++) begin
        if ((BASE + k - i) >= 0 && (BASE + k - i) < int'(W))
          acc = acc ^ (a_i[i] & b_i[BASE + k - i]);
      end
      p_o[k] = acc;
    end
  end

endmodule

// File: rtl/crcb_quot.sv
// First cycle: Barrett quotient of the top n bits of the (normal-order) state.
module crcb_quot
  import crcb_pkg::*;
(
  input  crc_word_t   state_i,
  input  logic [1:0]  width_i,
  input  crc_word_t   mu_i,
  output crc_word_t   quot_o
);

  crc_word_t   norm;
  crc_word_t   head;
  crc_word_t   mu_hi;
  int unsigned n;

  assign n    = adv_bits(width_i);
  assign norm = rev_word(state_i);

  always_comb begin
    head = norm >> (CRC_W - n);
  end

  crcb_clmul #(.W(CRC_W), .HIGH(1'b1)) i_mul_mu (
    .a_i (head),
    .b_i (mu_i),
    .p_o (mu_hi)
  );

  assign quot_o = head ^ mu_hi;

  // The quotient of head*x^W by a degree-W divisor has degree below n (R3).
  always_comb begin
    p_quot_degree_r3: assert ((quot_o >> n) == '0);
  end

endmodule

// File: rtl/crcb_fold.sv
// Second cycle: fold quotient times polynomial into the shifted state.
module crcb_fold
  import crcb_pkg::*;
(
  input  crc_word_t  state_i,
  input  logic [1:0] width_i,
  input  crc_word_t  quot_i,
  input  crc_word_t  poly_i,
  output crc_word_t  result_o
);

  crc_word_t   prod_lo;
  crc_word_t   shifted;
  int unsigned n;

  assign n = adv_bits(width_i);

  always_comb begin
    shifted = state_i >> n;
  end

  crcb_clmul #(.W(CRC_W), .HIGH(1'b0)) i_mul_poly (
    .a_i (quot_i),
    .b_i (poly_i),
    .p_o (prod_lo)
  );

  assign result_o = shifted ^ rev_word(prod_lo);

  // A zero quotient leaves only the shift (R8).
  always_comb begin
    p_zero_quot_r8: assert (quot_i != '0 || result_o == shifted);
  end

endmodule

// File: rtl/crcb_unit.sv
module crcb_unit
  import crcb_pkg::*;
#(
  parameter logic [31:0] POLY_A = 32'h04C11DB7,
  parameter logic [31:0] POLY_B = 32'h1EDC6F41
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] state_i,
  input  logic [1:0]  width_i,
  input  logic        poly_sel_i,
  output logic [31:0] result_o,
  output logic        done_o
);

  localparam crc_word_t MU_A = barrett_mu(POLY_A);
  localparam crc_word_t MU_B = barrett_mu(POLY_B);

  crc_word_t  mu_sel;
  crc_word_t  quot_d, quot_q;
  crc_word_t  state_d, state_q;
  logic [1:0] width_d, width_q;
  logic       psel_d, psel_q;
  logic       done_d, done_q;
  crc_word_t  poly_q;

  assign mu_sel = poly_sel_i ? MU_B : MU_A;

  crcb_quot i_quot (
    .state_i (state_i),
    .width_i (width_i),
    .mu_i    (mu_sel),
    .quot_o  (quot_d)
  );

  // Next-state: capture only on start (R6).
  always_comb begin
    state_d = state_q;
    width_d = width_q;
    psel_d  = psel_q;
    if (start_i) begin
      state_d = state_i;
      width_d = width_i;
      psel_d  = poly_sel_i;
    end
    done_d = start_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      width_q <= '0;
      psel_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      width_q <= width_d;
      psel_q  <= psel_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_q <= '0;
    end else if (start_i) begin
      quot_q <= quot_d;
    end
  end

  assign poly_q = psel_q ? POLY_B : POLY_A;

  crcb_fold i_fold (
    .state_i  (state_q),
    .width_i  (width_q),
    .quot_i   (quot_q),
    .poly_i   (poly_q),
    .result_o (result_o)
  );

  assign done_o = done_q;

  p_done_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  p_no_stray_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  p_hold_result_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o));

  p_zero_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_i == '0) |=> (result_o == '0));

endmodule

// File: tb/test_crcb_unit.sv
module test_crcb_unit;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 10;

  // {poly_sel, width, state}
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 32'hFFFFFFFF},
    {1'b0, 2'd1, 32'hFFFFFFFF},
    {1'b0, 2'd2, 32'hFFFFFFFF},
    {1'b1, 2'd0, 32'hFFFFFFFF},
    {1'b1, 2'd1, 32'h12345678},
    {1'b1, 2'd2, 32'hDEADBEEF},
    {1'b0, 2'd3, 32'hCAFEF00D},
    {1'b1, 2'd3, 32'h80000001},
    {1'b0, 2'd0, 32'h00000001},
    {1'b1, 2'd2, 32'h80000000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] state;
  logic [1:0]  width;
  logic        psel;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crcb_unit i_crcb_unit (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .state_i    (state),
    .width_i    (width),
    .poly_sel_i (psel),
    .result_o   (result),
    .done_o     (done)
  );

  function automatic logic [31:0] model(input logic [31:0] s, input logic [1:0] w, input logic p);
    logic [31:0] x;
    logic [31:0] pr;
    int n;
    x  = s;
    pr = p ? 32'h82F63B78 : 32'hEDB88320;
    n  = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    for (int i = 0; i < n; i++) x = (x >> 1) ^ (x[0] ? pr : 32'h0);
    return x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one operation at a negedge; check done and result one cycle later.
  task automatic op(input logic [31:0] s, input logic [1:0] w, input logic p, input string req);
    start = 1'b1; state = s; width = w; psel = p;
    @(negedge clk);
    start = 1'b0;
    chk("R2 done", {31'b0, done}, 32'd1);
    chk(req, result, model(s, w, p));
    @(negedge clk);
    chk("R2 single", {31'b0, done}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] held;
    rst_n = 1'b0; start = 1'b0; state = '0; width = '0; psel = 1'b0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk("R1 done in reset", {31'b0, done}, 32'd0);
    chk("R1 result in reset", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 done after reset", {31'b0, done}, 32'd0);
    chk("R1 result after reset", result, 32'd0);

    // Table walk: R3 / R4 / R5
    for (int v = 0; v < NVEC; v++) begin
      op(VEC[v][31:0], VEC[v][33:32], VEC[v][34], VEC[v][34] ? "R4 table" : "R3 table");
    end

    // Random states, every width code and both polynomials
    seed = 32'h1A2B3C4D;
    for (int k = 0; k < 32; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      op(seed, 2'(k % 4), k[2], k[2] ? "R4 random" : "R3 random");
    end

    // R5: codes 2 and 3 both mean 32
    op(32'h0F0F1234, 2'd3, 1'b0, "R5 code3");
    chk("R5 code3 equals code2", result, model(32'h0F0F1234, 2'd2, 1'b0));

    // R8: zero state
    for (int w = 0; w < 4; w++) begin
      op(32'h0, 2'(w), 1'b0, "R8 zero crc32");
      op(32'h0, 2'(w), 1'b1, "R8 zero crc32c");
    end

    // R6: input changes without start are ignored
    op(32'h55AA33CC, 2'd1, 1'b1, "R6 setup");
    held = model(32'h55AA33CC, 2'd1, 1'b1);
    state = 32'hFFFF0000; width = 2'd2; psel = 1'b0;
    @(negedge clk);
    chk("R6 hold 1", result, held);
    chk("R6 no done", {31'b0, done}, 32'd0);
    state = 32'h13572468; width = 2'd0;
    @(negedge clk);
    chk("R6 hold 2", result, held);

    // R7: back-to-back starts
    start = 1'b1; state = 32'hA5A5A5A5; width = 2'd0; psel = 1'b0;
    @(negedge clk);
    chk("R7 first done", {31'b0, done}, 32'd1);
    chk("R7 first", result, model(32'hA5A5A5A5, 2'd0, 1'b0));
    state = 32'h3C3C3C3C; width = 2'd2; psel = 1'b1;
    @(negedge clk);
    chk("R7 second done", {31'b0, done}, 32'd1);
    chk("R7 second", result, model(32'h3C3C3C3C, 2'd2, 1'b1));
    state = 32'h0BADF00D; width = 2'd1; psel = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R7 third", result, model(32'h0BADF00D, 2'd1, 1'b0));
    @(negedge clk);
    chk("R2 idle after burst", {31'b0, done}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule